// File: doc/BRIEF.md
# Half-Duty LCD Waveform Generator

This block turns two latched display banks into the drive codes for a liquid-crystal panel. It has two common lines and a parameterised set of segment lines, 60 by default. Every line is driven as a 2-bit code: high, mid or low. A separate analog stage turns these codes into bias voltages.

An oscillator input is divided down to a common-phase clock. The block runs in one of two modes:
- **Static mode:** both commons carry the same square wave, and only bank A is shown.
- **Half-duty mode:** the two commons take turns being selected. The common that is not selected sits at the mid level. Each segment then shows the bank that belongs to the selected common.

An external-select input makes the oscillator input itself the common phase, so slave devices can follow a master. In static mode this same path serves as an output expander: a low oscillator input gives each segment its data bit as a plain logic level, and a high one inverts them all. A blank input and a segment-test input override the display.

Top module: `lcd_halfduty_wavegen`

## Requirements
- R1: Lines are coded on 2 bits: high = 2'b10, mid = 2'b01, low = 2'b00. A segment line is only ever high or low. Segment n (n from 0) sits at seg_o[2n+1:2n] and is fed by bit n of each bank.
- R2: In static internal mode, com_a_o and com_b_o are equal.
  - They are high while the common phase is 1 and low while it is 0.
  - The phase starts at 1 after reset and toggles after every 4 rising edges of osc_in, giving a period of 8 oscillator cycles.
  - com_phase_o carries the phase.
- R3: A segment that is on drives the opposite level to the governing common phase. A segment that is off drives the same level as that phase.
- R4: In half-duty internal mode, the block steps through four states, moving on every 4 rising osc_in edges: A-selected/high, A-selected/low, B-selected/high, B-selected/low. The selected common follows the phase. The other common is mid.
- R5: In static mode, segment n shows bank A bit n, and bank B has no effect. In half-duty mode, it shows bank A bit n while common A is selected and bank B bit n while common B is selected.
- R6: With seg_test_i low, a low on blank_n_i turns every segment off.
- R7: A high on seg_test_i turns every segment on, whatever blank_n_i is.
- R8: With ext_sel_i high, the common phase and com_phase_o equal osc_in delayed by one clk cycle. In half-duty mode, the selected common swaps on every falling edge of osc_in, starting with common A.
- R9: With ext_sel_i high in static mode, an osc_in held low makes each segment high for a 1 bit and low for a 0 bit. An osc_in held high inverts every segment. Both commons follow osc_in.
- R10: dual_i and ext_sel_i are registered. Any change restarts the divider and the state counter, so after a change the internal modes begin again at phase 1 with common A selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_in | input | 1 | Oscillator input, or the external common phase |
| ext_sel_i | input | 1 | 1 = external common phase / expander, 0 = internal divider |
| dual_i | input | 1 | 1 = half-duty mode, 0 = static mode |
| blank_n_i | input | 1 | Low turns all segments off |
| seg_test_i | input | 1 | High turns all segments on (overrides blank) |
| bank_a_i | input | NSEG | Display bank A |
| bank_b_i | input | NSEG | Display bank B |
| com_a_o | output | 2 | Common A drive code |
| com_b_o | output | 2 | Common B drive code |
| seg_o | output | 2*NSEG | Segment drive codes, 2 bits per segment |
| com_phase_o | output | 1 | Common phase for slave devices |

## Verification
The hardest case to reach is the B-selected half of the half-duty frame. It appears only after eight or more counted oscillator rising edges, and it appears only if the block has not been restarted by a mode change along the way.

The bench keeps its own count of rising and falling edges from the moment of each mode change. It pulses the oscillator one edge at a time and checks every line after each edge, so every step of the four-state frame is compared against an arithmetic expectation. To prove bank selection, the two banks hold different patterns. A mode switch partway through a frame exercises the restart.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
    typedef logic [1:0] drv_t;

    localparam drv_t DRV_LOW  = 2'b00;
    localparam drv_t DRV_MID  = 2'b01;
    localparam drv_t DRV_HIGH = 2'b10;

    // Map a logic phase/level onto a two-level drive code.
    function automatic drv_t lvl(input logic b);
        return b ? DRV_HIGH : DRV_LOW;
    endfunction
endpackage

// File: rtl/lcdw_timebase.sv
module lcdw_timebase #(
    parameter int STEP_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    input  logic ext_sel_i,
    input  logic dual_i,
    output logic phase_o,
    output logic sel_b_o,
    output logic dual_o,
    output logic ext_o
);
    localparam int DIVW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [DIVW-1:0] DIV_LAST = DIVW'(STEP_DIV - 1);

    typedef struct packed {
        logic            osc_prev;
        logic            ext_ph;
        logic [DIVW-1:0] div;
        logic [1:0]      step;
        logic            dual;
        logic            ext;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      rise, fall, mode_chg;

    always_comb begin
        rise     = osc_in & ~st_q.osc_prev;
        fall     = ~osc_in & st_q.osc_prev;
        mode_chg = (dual_i != st_q.dual) || (ext_sel_i != st_q.ext);

        st_d          = st_q;
        st_d.osc_prev = osc_in;
        st_d.ext_ph   = osc_in;
        st_d.dual     = dual_i;
        st_d.ext      = ext_sel_i;

        if (mode_chg) begin
            st_d.div  = '0;
            st_d.step = '0;
        end else if (st_q.ext) begin
            // External phase: swap the selected common on each falling edge.
            if (fall) begin
                st_d.step = st_q.step + 2'd2;
            end
        end else if (rise) begin
            if (st_q.div == DIV_LAST) begin
                st_d.div  = '0;
                st_d.step = st_q.step + 2'd1;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.ext ? st_q.ext_ph : ~st_q.step[0];
    assign sel_b_o = st_q.step[1];
    assign dual_o  = st_q.dual;
    assign ext_o   = st_q.ext;
endmodule

// File: rtl/lcdw_common_drv.sv
module lcdw_common_drv
    import lcdw_pkg::*;
(
    input  logic phase_i,
    input  logic sel_b_i,
    input  logic dual_i,
    output drv_t com_a_o,
    output drv_t com_b_o
);
    drv_t active;

    always_comb begin
        active = lvl(phase_i);
        if (!dual_i) begin
            com_a_o = active;
            com_b_o = active;
        end else if (sel_b_i) begin
            com_a_o = DRV_MID;
            com_b_o = active;
        end else begin
            com_a_o = active;
            com_b_o = DRV_MID;
        end
    end
endmodule

// File: rtl/lcdw_seg_drv.sv
module lcdw_seg_drv
    import lcdw_pkg::*;
#(
    parameter int NSEG = 60
) (
    input  logic [NSEG-1:0]   bank_a_i,
    input  logic [NSEG-1:0]   bank_b_i,
    input  logic              sel_b_i,
    input  logic              dual_i,
    input  logic              phase_i,
    input  logic              blank_n_i,
    input  logic              seg_test_i,
    output logic [2*NSEG-1:0] seg_o
);
    logic use_b;

    assign use_b = dual_i & sel_b_i;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic bit_sel;
        logic on;

        assign bit_sel = use_b ? bank_b_i[g] : bank_a_i[g];
        assign on      = seg_test_i | (blank_n_i & bit_sel);
        assign seg_o[2*g +: 2] = lvl(on ^ phase_i);
    end
endmodule

// File: rtl/lcd_halfduty_wavegen.sv
module lcd_halfduty_wavegen
    import lcdw_pkg::*;
#(
    parameter int NSEG     = 60,
    parameter int STEP_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_in,
    input  logic              ext_sel_i,
    input  logic              dual_i,
    input  logic              blank_n_i,
    input  logic              seg_test_i,
    input  logic [NSEG-1:0]   bank_a_i,
    input  logic [NSEG-1:0]   bank_b_i,
    output logic [1:0]        com_a_o,
    output logic [1:0]        com_b_o,
    output logic [2*NSEG-1:0] seg_o,
    output logic              com_phase_o
);
    logic phase, sel_b, mode_dual, mode_ext;

    lcdw_timebase #(.STEP_DIV(STEP_DIV)) u_tbase (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_in    (osc_in),
        .ext_sel_i (ext_sel_i),
        .dual_i    (dual_i),
        .phase_o   (phase),
        .sel_b_o   (sel_b),
        .dual_o    (mode_dual),
        .ext_o     (mode_ext)
    );

    lcdw_common_drv u_com (
        .phase_i (phase),
        .sel_b_i (sel_b),
        .dual_i  (mode_dual),
        .com_a_o (com_a_o),
        .com_b_o (com_b_o)
    );

    lcdw_seg_drv #(.NSEG(NSEG)) u_seg (
        .bank_a_i   (bank_a_i),
        .bank_b_i   (bank_b_i),
        .sel_b_i    (sel_b),
        .dual_i     (mode_dual),
        .phase_i    (phase),
        .blank_n_i  (blank_n_i),
        .seg_test_i (seg_test_i),
        .seg_o      (seg_o)
    );

    assign com_phase_o = phase;
endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker
    import lcdw_pkg::*;
#(
    parameter int NSEG = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dual_i,
    input logic              ext_sel_i,
    input logic              blank_n_i,
    input logic              seg_test_i,
    input logic [1:0]        com_a_o,
    input logic [1:0]        com_b_o,
    input logic [2*NSEG-1:0] seg_o,
    input logic              mode_dual,
    input logic              mode_ext
);
    drv_t gov;

    assign gov = (com_a_o != DRV_MID) ? com_a_o : com_b_o;

    p_static_coms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_dual |-> (com_a_o == com_b_o) && (com_a_o != DRV_MID));

    p_half_one_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_dual |-> ((com_a_o == DRV_MID) != (com_b_o == DRV_MID)));

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((dual_i != mode_dual) && !ext_sel_i && !mode_ext) |=> (com_a_o == DRV_HIGH));

    for (genvar g = 0; g < NSEG; g++) begin : g_chk
        p_seg_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (seg_o[2*g +: 2] == DRV_HIGH) || (seg_o[2*g +: 2] == DRV_LOW));

        p_test_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
            seg_test_i |-> (seg_o[2*g +: 2] != gov));

        p_blank_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!seg_test_i && !blank_n_i) |-> (seg_o[2*g +: 2] == gov));
    end
endmodule

bind lcd_halfduty_wavegen lcdw_checker #(.NSEG(NSEG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dual_i     (dual_i),
    .ext_sel_i  (ext_sel_i),
    .blank_n_i  (blank_n_i),
    .seg_test_i (seg_test_i),
    .com_a_o    (com_a_o),
    .com_b_o    (com_b_o),
    .seg_o      (seg_o),
    .mode_dual  (mode_dual),
    .mode_ext   (mode_ext)
);

// File: tb/tb_lcd_halfduty_wavegen.sv
module tb_lcd_halfduty_wavegen;
    localparam int NSEG = 60;
    localparam logic [1:0] HI = 2'b10, MI = 2'b01, LO = 2'b00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_in = 1'b0, ext_sel_i = 1'b0, dual_i = 1'b0;
    logic blank_n_i = 1'b1, seg_test_i = 1'b0;
    logic [NSEG-1:0] bank_a_i = '0, bank_b_i = '0;
    logic [1:0] com_a_o, com_b_o;
    logic [2*NSEG-1:0] seg_o;
    logic com_phase_o;

    int checks = 0, fails = 0;
    int rises = 0, falls = 0;
    bit m_dual = 0, m_ext = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lcd_halfduty_wavegen #(.NSEG(NSEG)) dut (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .ext_sel_i(ext_sel_i),
        .dual_i(dual_i), .blank_n_i(blank_n_i), .seg_test_i(seg_test_i),
        .bank_a_i(bank_a_i), .bank_b_i(bank_b_i), .com_a_o(com_a_o),
        .com_b_o(com_b_o), .seg_o(seg_o), .com_phase_o(com_phase_o)
    );

    function automatic logic pat(input int k, input int i);
        return logic'(((i * 37 + k * 11 + (i >> 3)) >> 2) & 1);
    endfunction

    task automatic load_banks(input int k);
        for (int i = 0; i < NSEG; i++) begin
            bank_a_i[i] = pat(k, i);
            bank_b_i[i] = pat(k + 5, i);
        end
    endtask

    task automatic check(input string req);
        logic ph, selb, use_b, on;
        logic [1:0] ea, eb;
        logic [2*NSEG-1:0] es;
        if (m_ext) begin
            ph   = osc_in;
            selb = logic'(falls % 2);
        end else begin
            ph   = ~logic'((rises / 4) % 2);
            selb = logic'(((rises / 4) / 2) % 2);
        end
        if (!m_dual) begin
            ea = ph ? HI : LO; eb = ea;
        end else if (selb) begin
            ea = MI; eb = ph ? HI : LO;
        end else begin
            ea = ph ? HI : LO; eb = MI;
        end
        use_b = m_dual && selb;
        for (int i = 0; i < NSEG; i++) begin
            on = seg_test_i | (blank_n_i & (use_b ? bank_b_i[i] : bank_a_i[i]));
            es[2*i +: 2] = (on ^ ph) ? HI : LO;
        end
        checks++;
        if (com_a_o !== ea || com_b_o !== eb || com_phase_o !== ph) begin
            fails++;
            $display("FAIL %s: com_a=%b com_b=%b ph=%b expected %b %b %b", req,
                     com_a_o, com_b_o, com_phase_o, ea, eb, ph);
        end
        checks++;
        if (seg_o !== es) begin
            fails++;
            $display("FAIL %s: seg=%h expected %h", req, seg_o, es);
        end
    endtask

    task automatic set_mode(input bit d, input bit e);
        @(negedge clk);
        dual_i = d; ext_sel_i = e; osc_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        m_dual = d; m_ext = e; rises = 0; falls = 0;
    endtask

    task automatic osc_pulse(input string req);
        osc_in = 1'b1;
        @(negedge clk);
        if (!m_ext) rises++;
        check(req);
        osc_in = 1'b0;
        @(negedge clk);
        if (m_ext) falls++;
        check(req);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        load_banks(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset state phase high");

        // R2 R3 R5: static sweep, bank B differs and must not show
        for (int k = 0; k < 3; k++) begin
            load_banks(k);
            for (int p = 0; p < 10; p++) osc_pulse("R2 R3 R5 static");
        end

        // R4 R5: half-duty frames
        set_mode(1'b1, 1'b0);
        check("R10 half-duty restart");
        for (int k = 0; k < 2; k++) begin
            load_banks(k + 1);
            for (int p = 0; p < 20; p++) osc_pulse("R4 R5 half-duty");
        end

        // R6 R7: overrides in half-duty
        blank_n_i = 1'b0;
        for (int p = 0; p < 8; p++) osc_pulse("R6 blank");
        seg_test_i = 1'b1;
        for (int p = 0; p < 8; p++) osc_pulse("R7 test over blank");
        blank_n_i = 1'b1;
        for (int p = 0; p < 4; p++) osc_pulse("R7 test");
        seg_test_i = 1'b0;

        // R10: change mode mid-frame
        for (int p = 0; p < 6; p++) osc_pulse("R4 pre-restart");
        set_mode(1'b0, 1'b0);
        check("R10 restart to static");
        for (int p = 0; p < 5; p++) osc_pulse("R10 divider from zero");
        set_mode(1'b1, 1'b0);
        for (int p = 0; p < 9; p++) osc_pulse("R10 R4 after restart");

        // R8: external phase, half-duty
        set_mode(1'b1, 1'b1);
        check("R8 ext entry");
        load_banks(4);
        for (int p = 0; p < 8; p++) osc_pulse("R8 ext half-duty");

        // R9: expander
        set_mode(1'b0, 1'b1);
        check("R9 expander osc low");
        load_banks(6);
        @(negedge clk);
        check("R9 expander new data");
        osc_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 expander inverted");
        osc_in = 1'b0;
        @(negedge clk);
        check("R9 expander restored");
        blank_n_i = 1'b0;
        @(negedge clk);
        check("R6 expander blank");
        blank_n_i = 1'b1;

        done = 1;
        finish_run();
    end
endmodule